// File: doc/BRIEF.md
# Addressed Serial Relay Control Register

This block is a three-wire serial slave that configures a bank of eight relay driver enables. A host lowers chip select, clocks a frame in most significant bit first, and raises chip select to commit it. In the default addressed form a frame is sixteen bits long: an eight-bit register address followed by eight data bits. One address loads the relay enable register. A second address loads a three-bit power-save level code. Every other address leaves both registers untouched. A parameter selects a shorter form with no address, where each eight-bit frame loads the relay enables directly.

The last stage of the shift register is brought out as a serial output, so several blocks can be chained on one chip select. Two active-low override inputs act on the registers: one clears everything and one turns every relay on. The clear input wins when both are low. Each commit also raises a one-cycle write strobe, which starts the timing of an external power-save controller.

The serial pins are sampled in a system clock domain, which must run at least four times faster than the serial clock. They pass through synchronizers and edge detectors before any logic uses them.

Top module: `relay_spi_regs`

## Requirements
- R1: After the system reset `rst_n` is released, `relay_on` is 0, `ps_code` is 0 and `ser_out` is 0, in both frame forms.
- R2: While `cs_n` is low, each rising edge of `sclk` shifts `sdi` into the shift register. The frame is sent MSB first: address bits 7..0 come first, then data bits 7..0.
- R3: Committing a frame whose address is 8'h00 loads the data byte into `relay_on`. Data bit n drives `relay_on[n]`, which is output n+1; for example, data 8'h04 turns on `relay_on[2]` only.
- R4: Committing a frame whose address is 8'h01 loads data bits [2:0] into `ps_code`. `relay_on` is unchanged.
- R5: Committing a frame with any address other than 8'h00 or 8'h01 changes neither `relay_on` nor `ps_code`.
- R6: The registers change only when `cs_n` rises. While `cs_n` is low, `relay_on` and `ps_code` keep their previous values.
- R7: If more or fewer bits than the frame width arrive while `cs_n` is low, the commit uses the last frame-width bits received. Bits left from earlier frames fill the gap when too few arrive.
- R8: `ser_out` is the last stage of the shift register. After each falling edge of `sclk` it equals the bit received 16 rising edges earlier (8 in the short form).
- R9: While `cs_n` is high, `sclk` and `sdi` have no effect, and `ser_out` shows the oldest of the retained bits (the first bit of the last full frame).
- R10: While `clr_n` is low, `relay_on`, `ps_code`, the shift register and `ser_out` are cleared. While `set_n` is low and `clr_n` is high, `relay_on` is all ones. With both low, `clr_n` wins and `relay_on` is 0. The forced value remains after the override is released.
- R11: Each rising edge of `cs_n` produces exactly one `wr_strobe` pulse, one system clock long. The pulse comes in the same cycle that the committed values appear.
- R12: With `ADDRESSED` = 0 the frame is 8 bits with no address. Each commit loads the eight bits into `relay_on`: the first bit sent becomes `relay_on[7]` and the last becomes `relay_on[0]`. `ps_code` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select; its rising edge commits the frame |
| sdi | input | 1 | Serial data in |
| set_n | input | 1 | Active-low override that turns all relays on |
| clr_n | input | 1 | Active-low override that clears all state; takes priority over `set_n` |
| ser_out | output | 1 | Serial data out for daisy chaining |
| relay_on | output | 8 | Relay driver enables; bit n is output n+1 |
| ps_code | output | 3 | Power-save level code |
| wr_strobe | output | 1 | One-cycle pulse on each commit |

## Verification
The assertions assume the serial pins are slow compared with `clk`. Each level of `sclk` and `cs_n` must last several system clocks, so that every edge is detected once and there are never two commits in consecutive cycles. They also assume `sdi` is stable around each rising edge of `sclk`. The stimulus holds every serial level for five system clocks, changes `sdi` only while `sclk` is low, and separates frames by several idle cycles. Within those limits, the random frames vary the address, the data and the bit count, including frames that are too short or too long.

// File: rtl/relay_spi_pkg.sv
package relay_spi_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int PS_W   = 3;

  localparam logic [ADDR_W-1:0] ADDR_RELAY = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_PSAVE = 8'h01;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_RELAY = 2'd1,
    TGT_PSAVE = 2'd2
  } reg_target_e;

  // Map an address byte to the register it selects.
  function automatic reg_target_e decode_target(input logic [ADDR_W-1:0] addr);
    if (addr == ADDR_RELAY)      return TGT_RELAY;
    else if (addr == ADDR_PSAVE) return TGT_PSAVE;
    else                         return TGT_NONE;
  endfunction

  // Power-save code held in the low data bits.
  function automatic logic [PS_W-1:0] ps_field(input logic [DATA_W-1:0] data);
    return data[PS_W-1:0];
  endfunction

endpackage

// File: rtl/relay_spi_sync.sv
module relay_spi_sync #(
  parameter int                 WIDTH     = 1,
  parameter int                 STAGES    = 2,
  parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RESET_VAL;
          else        chain[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RESET_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/relay_spi_shifter.sv
module relay_spi_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               shift_en,
  input  logic               fall_en,
  input  logic               selected,
  input  logic               din,
  output logic [FRAME_W-1:0] frame,
  output logic               dout
);

  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (clear)    sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[FRAME_W-2:0], din};
  end

  // Output stage follows the last shift stage on falling serial edges,
  // and continuously while deselected.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    dout <= 1'b0;
    else if (clear)                dout <= 1'b0;
    else if (fall_en || !selected) dout <= sr_q[FRAME_W-1];
  end

  assign frame = sr_q;

endmodule

// File: rtl/relay_spi_regfile.sv
module relay_spi_regfile
  import relay_spi_pkg::*;
#(
  parameter int FRAME_W   = 16,
  parameter bit ADDRESSED = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               force_clr,
  input  logic               force_set,
  input  logic               commit,
  input  logic [FRAME_W-1:0] frame,
  output logic [DATA_W-1:0]  relay_on,
  output logic [PS_W-1:0]    ps_code,
  output logic               wr_strobe
);

  logic [DATA_W-1:0] data_byte;
  reg_target_e       target;
  logic              relay_we;
  logic              ps_we;

  generate
    if (ADDRESSED) begin : g_addr
      assign data_byte = frame[DATA_W-1:0];
      assign target    = decode_target(frame[FRAME_W-1 -: ADDR_W]);
    end else begin : g_plain
      assign data_byte = frame;
      assign target    = TGT_RELAY;
    end
  endgenerate

  assign relay_we = commit && (target == TGT_RELAY);
  assign ps_we    = commit && (target == TGT_PSAVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         relay_on <= '0;
    else if (force_clr) relay_on <= '0;
    else if (force_set) relay_on <= '1;
    else if (relay_we)  relay_on <= data_byte;
  end

  generate
    if (ADDRESSED) begin : g_ps
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ps_code <= '0;
        else if (force_clr) ps_code <= '0;
        else if (ps_we)     ps_code <= ps_field(data_byte);
      end
    end else begin : g_nops
      logic unused_ps;
      assign unused_ps = ps_we;
      assign ps_code   = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_strobe <= 1'b0;
    else        wr_strobe <= commit;
  end

endmodule

// File: rtl/relay_spi_regs.sv
module relay_spi_regs
  import relay_spi_pkg::*;
#(
  parameter bit ADDRESSED   = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              set_n,
  input  logic              clr_n,
  output logic              ser_out,
  output logic [DATA_W-1:0] relay_on,
  output logic [PS_W-1:0]   ps_code,
  output logic              wr_strobe
);

  localparam int FRAME_W = ADDRESSED ? (ADDR_W + DATA_W) : DATA_W;

  // Synchronized pins: {sclk, cs_n, sdi, set_n, clr_n}
  logic [4:0] pins_s;
  logic       sclk_s, cs_n_s, sdi_s, set_n_s, clr_n_s;

  relay_spi_sync #(
    .WIDTH    (5),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(5'b01011)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in({sclk, cs_n, sdi, set_n, clr_n}),
    .sync_out(pins_s)
  );

  assign {sclk_s, cs_n_s, sdi_s, set_n_s, clr_n_s} = pins_s;

  // Edge detection on the synchronized serial clock and select.
  logic sclk_q, cs_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_n_q <= cs_n_s;
    end
  end

  // Named internal events, also observed by the checker.
  logic sclk_rise, sclk_fall, selected, shift_evt, upd_evt;
  logic force_clr, force_set;
  logic [FRAME_W-1:0] frame_bits;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign selected  = ~cs_n_s;
  assign shift_evt = sclk_rise & selected;
  assign upd_evt   = cs_n_s & ~cs_n_q;
  assign force_clr = ~clr_n_s;
  assign force_set = ~set_n_s;

  relay_spi_shifter #(
    .FRAME_W(FRAME_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (force_clr),
    .shift_en(shift_evt),
    .fall_en (sclk_fall),
    .selected(selected),
    .din     (sdi_s),
    .frame   (frame_bits),
    .dout    (ser_out)
  );

  relay_spi_regfile #(
    .FRAME_W  (FRAME_W),
    .ADDRESSED(ADDRESSED)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .force_clr(force_clr),
    .force_set(force_set),
    .commit   (upd_evt),
    .frame    (frame_bits),
    .relay_on (relay_on),
    .ps_code  (ps_code),
    .wr_strobe(wr_strobe)
  );

endmodule

// File: rtl/relay_spi_regs_chk.sv
module relay_spi_regs_chk #(
  parameter int FRAME_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               upd_evt,
  input logic               shift_evt,
  input logic               force_clr,
  input logic               force_set,
  input logic [7:0]         relay_on,
  input logic [2:0]         ps_code,
  input logic               wr_strobe,
  input logic [FRAME_W-1:0] frame_bits
);

  assert_relay_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_evt && !force_clr && !force_set) |=> $stable(relay_on));

  assert_ps_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_evt && !force_clr) |=> $stable(ps_code));

  assert_shift_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_evt && !force_clr) |=> $stable(frame_bits));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    force_clr |=> (relay_on == 8'h00 && ps_code == 3'd0 && frame_bits == '0));

  assert_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (force_set && !force_clr) |=> (relay_on == 8'hFF));

  assert_strobe_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> wr_strobe);

  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

endmodule

bind relay_spi_regs relay_spi_regs_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_evt   (upd_evt),
  .shift_evt (shift_evt),
  .force_clr (force_clr),
  .force_set (force_set),
  .relay_on  (relay_on),
  .ps_code   (ps_code),
  .wr_strobe (wr_strobe),
  .frame_bits(frame_bits)
);

// File: tb/relay_spi_regs_test.sv
module relay_spi_regs_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, set_n = 1'b1, clr_n = 1'b1;

  logic       dout_a, dout_b, stb_a, stb_b;
  logic [7:0] relay_a, relay_b;
  logic [2:0] ps_a, ps_b;

  always #5 clk = ~clk;

  relay_spi_regs #(.ADDRESSED(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .set_n(set_n), .clr_n(clr_n), .ser_out(dout_a), .relay_on(relay_a),
    .ps_code(ps_a), .wr_strobe(stb_a));

  relay_spi_regs #(.ADDRESSED(1'b0)) uut_b (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .set_n(set_n), .clr_n(clr_n), .ser_out(dout_b), .relay_on(relay_b),
    .ps_code(ps_b), .wr_strobe(stb_b));

  int checks = 0;
  int errors = 0;
  int strobes_a = 0;
  int strobes_b = 0;
  bit done = 0;

  // Bench models
  logic [15:0] mdl_a = '0;
  logic [7:0]  mdl_b = '0;
  logic [7:0]  exp_relay_a = '0, exp_relay_b = '0;
  logic [2:0]  exp_ps = '0;

  always @(posedge clk) begin
    if (stb_a) strobes_a++;
    if (stb_b) strobes_b++;
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected register update for a committed 16-bit frame.
  function automatic logic [1:0] frame_kind(input logic [15:0] f);
    if (f[15:8] == 8'h00) return 2'd1;
    if (f[15:8] == 8'h01) return 2'd2;
    return 2'd0;
  endfunction

  task automatic send_bit(input logic b);
    sdi = b;
    wait_clks(5);
    sclk = 1'b1;
    mdl_a = {mdl_a[14:0], b};
    mdl_b = {mdl_b[6:0], b};
    wait_clks(5);
    sclk = 1'b0;
    wait_clks(5);
    chk(16'(dout_a), 16'(mdl_a[15]), "R8 ser_out 16-bit delay");
    chk(16'(dout_b), 16'(mdl_b[7]),  "R12 ser_out 8-bit delay");
  endtask

  task automatic send_frame(input logic [31:0] word, input int nbits);
    int sa, sb;
    sa = strobes_a;
    sb = strobes_b;
    cs_n = 1'b0;
    wait_clks(5);
    for (int i = nbits - 1; i >= 0; i--) begin
      send_bit(word[i]);
      if (i == nbits / 2) begin
        chk(16'(relay_a), 16'(exp_relay_a), "R6 relay held while selected");
        chk(16'(ps_a), 16'(exp_ps), "R6 ps held while selected");
      end
    end
    wait_clks(3);
    cs_n = 1'b1;
    wait_clks(8);
    case (frame_kind(mdl_a))
      2'd1: exp_relay_a = mdl_a[7:0];
      2'd2: exp_ps = mdl_a[2:0];
      default: ;
    endcase
    exp_relay_b = mdl_b;
    chk(16'(relay_a), 16'(exp_relay_a), "R3 R5 R7 relay after commit");
    chk(16'(ps_a), 16'(exp_ps), "R4 R5 ps after commit");
    chk(16'(relay_b), 16'(exp_relay_b), "R12 short-form relay");
    chk(16'(ps_b), 16'h0, "R12 short-form ps");
    chk(16'(strobes_a - sa), 16'd1, "R11 one strobe per commit");
    chk(16'(strobes_b - sb), 16'd1, "R11 short-form strobe");
    chk(16'(dout_a), 16'(mdl_a[15]), "R9 ser_out when deselected");
    wait_clks(4);
  endtask

  initial begin
    logic [31:0] seed_val;
    seed_val = $urandom(32'd1357);
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(4);
    // R1 reset state
    chk(16'(relay_a), 16'h0, "R1 relay reset");
    chk(16'(ps_a), 16'h0, "R1 ps reset");
    chk(16'(dout_a), 16'h0, "R1 ser_out reset");
    chk(16'(relay_b), 16'h0, "R1 short-form relay reset");

    // R2 R3 directed: address 00, data A5, then single-bit mapping
    send_frame({16'h0, 8'h00, 8'hA5}, 16);
    chk(16'(relay_a), 16'h00A5, "R2 R3 directed relay A5");
    send_frame({16'h0, 8'h00, 8'h04}, 16);
    chk(16'(relay_a), 16'h0004, "R3 data 04 drives relay_on[2]");
    // R4 and R5
    send_frame({16'h0, 8'h01, 8'hFE}, 16);
    chk(16'(ps_a), 16'h0006, "R4 ps code from data[2:0]");
    send_frame({16'h0, 8'h5A, 8'hFF}, 16);
    chk(16'(relay_a), 16'h0004, "R5 unknown address keeps relay");
    // R7 long and short frames
    send_frame({8'h0, 8'hC3, 8'h00, 8'h81}, 24);
    chk(16'(relay_a), 16'h0081, "R7 long frame keeps last 16");
    send_frame({20'h0, 4'h0, 8'h3C}, 12);

    // R9: toggling with cs_n high has no effect
    begin
      logic d0;
      logic [7:0] r0;
      d0 = dout_a;
      r0 = relay_a;
      for (int k = 0; k < 10; k++) begin
        sdi = k[0];
        sclk = 1'b1;
        wait_clks(5);
        sclk = 1'b0;
        wait_clks(5);
      end
      chk(16'(dout_a), 16'(d0), "R9 ser_out unchanged while deselected");
      chk(16'(relay_a), 16'(r0), "R9 relay unchanged while deselected");
    end
    send_frame({16'h0, 8'h00, 8'h69}, 16);

    // R10 overrides
    set_n = 1'b0;
    wait_clks(6);
    chk(16'(relay_a), 16'h00FF, "R10 set forces all on");
    chk(16'(relay_b), 16'h00FF, "R10 short-form set");
    set_n = 1'b1;
    wait_clks(6);
    chk(16'(relay_a), 16'h00FF, "R10 set value kept after release");
    exp_relay_a = 8'hFF;
    send_frame({16'h0, 8'h01, 8'h03}, 16);
    clr_n = 1'b0;
    set_n = 1'b0;
    wait_clks(6);
    chk(16'(relay_a), 16'h0, "R10 clear wins over set");
    chk(16'(ps_a), 16'h0, "R10 clear resets ps");
    chk(16'(dout_a), 16'h0, "R10 clear resets ser_out");
    set_n = 1'b1;
    wait_clks(2);
    clr_n = 1'b1;
    wait_clks(6);
    chk(16'(relay_a), 16'h0, "R10 cleared value kept");
    mdl_a = '0; mdl_b = '0;
    exp_relay_a = '0; exp_relay_b = '0; exp_ps = '0;

    // Random frames
    for (int n = 0; n < 60; n++) begin
      logic [31:0] w;
      logic [7:0]  ad;
      int nb, sel;
      w = $urandom;
      sel = int'($urandom % 4);
      ad = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h01 : w[23:16];
      w[15:0] = {ad, w[7:0]};
      nb = (($urandom % 5) == 0) ? int'(10 + $urandom % 15) : 16;
      send_frame(w, nb);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule